// File: doc/BRIEF.md
# MDIO Management Master

This block is the station management master of an Ethernet MAC. It runs a single register read or write on an external PHY over the two-wire management bus. The bus has a clock, MDC, that only this master drives, and one data line, MDIO, that both sides share.

Software programs a transfer with one control write. That write carries the PHY address, the register index, the direction, a host-clock range code and the busy bit. The block then runs the whole serial frame by itself. The range code picks an even divide ratio that keeps MDC between 1 and 2.5 MHz for the host clock in use. Software polls `busy` and sees it drop when the frame is over. A write takes its payload from the data register, which software loads first. A read leaves the PHY's answer in that same register.

The control path is one state machine with five states:
- `ST_IDLE`: waits for a start.
- `ST_PREAMBLE`: sends 32 ones.
- `ST_HEADER`: sends the start code, the opcode and both addresses.
- `ST_TURN`: sends or releases the two turnaround bits.
- `ST_DATA`: moves the sixteen data bits.

The transitions are:
- start: `ST_IDLE` to `ST_PREAMBLE`.
- preamble-done: `ST_PREAMBLE` to `ST_HEADER`.
- header-done: `ST_HEADER` to `ST_TURN`.
- turn-done: `ST_TURN` to `ST_DATA`.
- frame-done: `ST_DATA` to `ST_IDLE`.

Each of the last four transitions fires on the MDC falling edge that ends the last bit of its phase.

Top module: `mdio_master`

## Requirements
- R1: Range codes 0, 1, 2, 3 and 4 select MDC divide ratios of 16, 26, 42, 62 and 102 host cycles. Within every MDC period, MDC is low for the first half-ratio cycles and high for the second half-ratio cycles.
- R2: Range codes 5, 6 and 7 select the ratio 102.
- R3: While idle, MDC is low and `mdio_oe` is low. A control write with `ctl_start` high, made while idle, raises `busy` on the next cycle.
- R4: Every frame, in bit order, carries: 32 ones, start code 0 then 1, opcode 1,0 for a read (`ctl_write`=0) or 0,1 for a write (`ctl_write`=1), the 5-bit PHY address MSB first, and the 5-bit register address MSB first.
- R5: A write frame then drives turnaround 1,0 and the 16 bits of the data register, MSB first.
- R6: A read frame releases MDIO (`mdio_oe`=0) for the two turnaround bits and the 16 data bits. The data bits are sampled on rising MDC, MSB first, and show on `rd_data` when `busy` falls.
- R7: `mdio_o` and `mdio_oe` change only on the host cycle where MDC falls, or when a frame starts. They never change while MDC stays high.
- R8: `busy` stays high for exactly 64 MDC periods, which is 64 times the ratio in host cycles. It then clears by itself.
- R9: While `busy` is high, control writes and data-register writes are ignored. The frame in progress is unchanged, no second frame follows, and `rd_data` holds its value.
- R10: After reset, `busy`, `mdc` and `mdio_oe` are 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | host clock |
| rst_n | input | 1 | active-low asynchronous reset |
| ctl_we | input | 1 | control register write strobe |
| ctl_phy_addr | input | 5 | PHY address field |
| ctl_reg_addr | input | 5 | PHY register index field |
| ctl_write | input | 1 | 1 = write transfer, 0 = read transfer |
| ctl_range | input | 3 | host-clock range code |
| ctl_start | input | 1 | busy bit written with the control word |
| data_we | input | 1 | data register write strobe |
| data_wdata | input | 16 | data register write value |
| busy | output | 1 | transfer in progress |
| rd_data | output | 16 | data register contents |
| mdc | output | 1 | management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
The bench models a PHY that samples MDIO on every rising MDC edge and answers reads on falling edges. It measures each high and low MDC run, so it can flag any divide ratio off by one, an odd split, or a wrong fallback for the unused codes 5 to 7.

It counts the host cycles spent busy, which exposes a frame that drops or adds a bit. It checks that read frames release the line through turnaround. A design that sampled on the wrong edge, or shifted LSB first, would return a PHY answer that does not match.

One transfer is hit with a second control write and a data write while busy. A design that took either write would corrupt the frame, start a second frame, or overwrite the read result.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int DIV_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA
    } mdio_state_e;

    // Range code to MDC divide ratio; undefined codes use the slowest ratio.
    function automatic logic [DIV_W-1:0] ratio_of_code(input logic [2:0] code);
        unique case (code)
            3'd0:    return DIV_W'(16);
            3'd1:    return DIV_W'(26);
            3'd2:    return DIV_W'(42);
            3'd3:    return DIV_W'(62);
            default: return DIV_W'(102);
        endcase
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] ratio,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] half;

    assign half     = ratio >> 1;
    assign rise_stb = run && (cnt_q == half - DIV_W'(1));
    assign fall_stb = run && (cnt_q == ratio - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else begin
            cnt_q <= fall_stb ? '0 : cnt_q + DIV_W'(1);
            if (rise_stb)      mdc <= 1'b1;
            else if (fall_stb) mdc <= 1'b0;
        end
    end
endmodule

// File: rtl/mdio_frame_ctl.sv
module mdio_frame_ctl
    import mdio_pkg::*;
#(
    parameter int PRE_BITS = 32,
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_op,
    input  logic [ADDR_W-1:0] phy,
    input  logic [ADDR_W-1:0] rg,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rx_data
);
    localparam int SR_W     = 4 + 2*ADDR_W + 2 + DATA_W;
    localparam int TOTAL    = PRE_BITS + SR_W;
    localparam int CNT_W    = $clog2(TOTAL);
    localparam logic [CNT_W-1:0] LAST_PRE = CNT_W'(PRE_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_HDR = CNT_W'(PRE_BITS + 4 + 2*ADDR_W - 1);
    localparam logic [CNT_W-1:0] LAST_TA  = CNT_W'(PRE_BITS + 4 + 2*ADDR_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(TOTAL - 1);

    mdio_state_e       state_q, state_d;
    logic [CNT_W-1:0]  bit_q;
    logic [SR_W-1:0]   sr_q;
    logic [DATA_W-1:0] rx_q;
    logic              rd_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start)                        state_d = ST_PREAMBLE;
            ST_PREAMBLE: if (fall_stb && bit_q == LAST_PRE) state_d = ST_HEADER;
            ST_HEADER:   if (fall_stb && bit_q == LAST_HDR) state_d = ST_TURN;
            ST_TURN:     if (fall_stb && bit_q == LAST_TA)  state_d = ST_DATA;
            ST_DATA:     if (fall_stb && bit_q == LAST_BIT) state_d = ST_IDLE;
            default:                                        state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= '0;
            sr_q  <= '0;
            rx_q  <= '0;
            rd_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE) begin
                if (start) begin
                    bit_q <= '0;
                    rd_q  <= rd_op;
                    sr_q  <= {2'b01, rd_op ? 2'b10 : 2'b01, phy, rg,
                              rd_op ? 2'b11 : 2'b10,
                              rd_op ? {DATA_W{1'b1}} : wdata};
                end
            end else if (fall_stb) begin
                bit_q <= bit_q + CNT_W'(1);
                if (state_q != ST_PREAMBLE) sr_q <= sr_q << 1;
            end
            if (rise_stb && state_q == ST_DATA && rd_q)
                rx_q <= {rx_q[DATA_W-2:0], mdio_i};
        end
    end

    // outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        mdio_o  = (state_q == ST_IDLE || state_q == ST_PREAMBLE) ? 1'b1 : sr_q[SR_W-1];
        mdio_oe = busy && !(rd_q && (state_q == ST_TURN || state_q == ST_DATA));
        done    = (state_q == ST_DATA) && fall_stb && (bit_q == LAST_BIT);
        rx_data = rx_q;
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [ADDR_W-1:0] ctl_phy_addr,
    input  logic [ADDR_W-1:0] ctl_reg_addr,
    input  logic              ctl_write,
    input  logic [2:0]        ctl_range,
    input  logic              ctl_start,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_wdata,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic             accept;
    logic             rise_stb, fall_stb, done, rd_q;
    logic [DIV_W-1:0] ratio_q;
    logic [DATA_W-1:0] data_q, rx_data;

    assign accept  = ctl_we && ctl_start && !busy;
    assign rd_data = data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ratio_q <= DIV_W'(16);
            data_q  <= '0;
            rd_q    <= 1'b0;
        end else begin
            if (accept) begin
                ratio_q <= ratio_of_code(ctl_range);
                rd_q    <= !ctl_write;
            end
            if (data_we && !busy) data_q <= data_wdata;
            else if (done && rd_q) data_q <= rx_data;
        end
    end

    mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .ratio    (ratio_q),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_ctl #(.PRE_BITS(32), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .rd_op    (!ctl_write),
        .phy      (ctl_phy_addr),
        .rg       (ctl_reg_addr),
        .wdata    (data_q),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (done),
        .rx_data  (rx_data)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_we,
    input logic              ctl_start,
    input logic              data_we,
    input logic              busy,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe,
    input logic [DATA_W-1:0] rd_data
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe)); // R3

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_start && !busy) |=> busy); // R3

    AST_MDIO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R7

    AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $past(data_we)) |-> $stable(rd_data)); // R9

    AST_BUSY_MDC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> busy); // R8
endmodule

bind mdio_master mdio_master_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_start (ctl_start),
    .data_we   (data_we),
    .busy      (busy),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .rd_data   (rd_data)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    typedef struct packed {
        logic        wr;
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic [15:0] data;
        logic [6:0]  ratio;
    } xfer_t;

    logic clk = 0, rst_n = 0;
    logic ctl_we = 0, ctl_write = 0, ctl_start = 0, data_we = 0, mdio_i = 1;
    logic [4:0] ctl_phy_addr = 0, ctl_reg_addr = 0;
    logic [2:0] ctl_range = 0;
    logic [15:0] data_wdata = 0;
    logic busy, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;

    int n_vec = 0, n_bad = 0, cyc = 0;
    xfer_t q[$];
    logic [63:0] bits, oes;
    int nbit, run_len, hi_min, hi_max, lo_min, lo_max, busy_cyc;
    logic prev_mdc = 0, prev_busy = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_master u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_phy_addr(ctl_phy_addr),
        .ctl_reg_addr(ctl_reg_addr), .ctl_write(ctl_write), .ctl_range(ctl_range),
        .ctl_start(ctl_start), .data_we(data_we), .data_wdata(data_wdata),
        .busy(busy), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] phy_answer(input logic [4:0] p, input logic [4:0] r);
        return {3'b101, r, p, 3'b011};
    endfunction

    function automatic logic [6:0] ratio_ref(input logic [2:0] code);
        case (code)
            3'd0: return 7'd16;
            3'd1: return 7'd26;
            3'd2: return 7'd42;
            3'd3: return 7'd62;
            default: return 7'd102;
        endcase
    endfunction

    // driver: program and start one transfer, push its expectation
    task automatic do_xfer(input logic wr, input logic [4:0] p, input logic [4:0] r,
                           input logic [15:0] d, input logic [2:0] code);
        xfer_t it;
        @(negedge clk);
        data_we = 1; data_wdata = d;
        @(negedge clk);
        data_we = 0;
        ctl_we = 1; ctl_start = 1; ctl_write = wr;
        ctl_phy_addr = p; ctl_reg_addr = r; ctl_range = code;
        it.wr = wr; it.phy = p; it.rg = r; it.ratio = ratio_ref(code);
        it.data = wr ? d : phy_answer(p, r);
        q.push_back(it);
        @(negedge clk);
        ctl_we = 0; ctl_start = 0;
        chk(busy === 1'b1, "R3 busy after start", {31'd0, busy}, 1);
    endtask

    task automatic wait_idle();
        while (busy !== 1'b0 || q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor / PHY model / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !prev_busy) begin
                nbit = 0; run_len = 0; busy_cyc = 0; bits = '0; oes = '0;
                hi_min = 1000; hi_max = 0; lo_min = 1000; lo_max = 0;
            end
            if (busy) busy_cyc++;
            if (busy || prev_busy) begin
                if (mdc != prev_mdc && busy) begin
                    if (prev_mdc) begin
                        if (run_len < hi_min) hi_min = run_len;
                        if (run_len > hi_max) hi_max = run_len;
                    end else begin
                        if (run_len < lo_min) lo_min = run_len;
                        if (run_len > lo_max) lo_max = run_len;
                    end
                    run_len = 1;
                end else run_len++;
            end
            if (mdc && !prev_mdc && nbit < 64) begin
                bits[63-nbit] = mdio_oe ? mdio_o : mdio_i;
                oes[63-nbit]  = mdio_oe;
                nbit++;
            end
            if (!mdc && prev_mdc && q.size() != 0) begin
                if (!q[0].wr && nbit >= 47 && nbit < 64)
                    mdio_i = (nbit == 47) ? 1'b0 : q[0].data[15-(nbit-48)];
                else mdio_i = 1'b1;
            end
            if (!busy && prev_busy) begin
                xfer_t it;
                mdio_i = 1'b1;
                if (q.size() == 0) begin
                    chk(0, "R9 unexpected frame", 1, 0);
                end else begin
                    it = q.pop_front();
                    chk(nbit == 64, "R8 bit count", nbit, 64);
                    chk(busy_cyc == 64*it.ratio, "R8 busy cycles", busy_cyc, 64*it.ratio);
                    chk(hi_min == it.ratio/2 && hi_max == it.ratio/2, "R1 R2 mdc high", hi_max, it.ratio/2);
                    chk(lo_min == it.ratio/2 && lo_max == it.ratio/2, "R1 R2 mdc low", lo_min, it.ratio/2);
                    chk(bits[63:32] == 32'hFFFF_FFFF, "R4 preamble", bits[63:32], 32'hFFFF_FFFF);
                    chk(bits[31:18] == {2'b01, it.wr ? 2'b01 : 2'b10, it.phy, it.rg},
                        "R4 header", bits[31:18], {2'b01, it.wr ? 2'b01 : 2'b10, it.phy, it.rg});
                    if (it.wr) begin
                        chk(bits[17:0] == {2'b10, it.data}, "R5 write ta+data", bits[17:0], {2'b10, it.data});
                        chk(oes == '1, "R5 driven", oes[31:0], 32'hFFFF_FFFF);
                    end else begin
                        chk(oes[17:0] == '0, "R6 released", oes[17:0], 0);
                        chk(oes[63:18] == '1, "R6 driven header", oes[49:18], 32'hFFFF_FFFF);
                        chk(rd_data == it.data, "R6 read data", rd_data, it.data);
                    end
                end
            end
        end
        prev_mdc = mdc;
        prev_busy = busy;
    end

    logic done_flag = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done_flag) begin
            done_flag = 1;
            chk(0, "watchdog", cyc, WATCHDOG);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 0 && mdc === 0 && mdio_oe === 0, "R10 reset outputs", {busy, mdc, mdio_oe}, 0);
        chk(rd_data === 16'h0, "R10 reset data", rd_data, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk(busy === 0 && mdc === 0 && mdio_oe === 0, "R3 idle quiet", {busy, mdc, mdio_oe}, 0);

        do_xfer(1, 5'h01, 5'h00, 16'hA53C, 3'd0); wait_idle();   // R1 R5
        do_xfer(0, 5'h1F, 5'h11, 16'h0000, 3'd1); wait_idle();   // R1 R6
        do_xfer(1, 5'h10, 5'h1E, 16'h8001, 3'd2); wait_idle();   // R1 R5
        do_xfer(0, 5'h0A, 5'h15, 16'h0000, 3'd3); wait_idle();   // R1 R6
        do_xfer(1, 5'h15, 5'h0A, 16'h7FFE, 3'd4); wait_idle();   // R1 R4
        do_xfer(0, 5'h03, 5'h1C, 16'h0000, 3'd6); wait_idle();   // R2
        do_xfer(1, 5'h00, 5'h1F, 16'h0F0F, 3'd5); wait_idle();   // R2

        // R9: writes while busy are ignored
        do_xfer(0, 5'h12, 5'h07, 16'h0000, 3'd0);
        repeat (100) @(negedge clk);
        ctl_we = 1; ctl_start = 1; ctl_write = 1; ctl_phy_addr = 5'h05;
        ctl_reg_addr = 5'h09; ctl_range = 3'd4; data_we = 1; data_wdata = 16'h1234;
        @(negedge clk);
        ctl_we = 0; ctl_start = 0; data_we = 0;
        chk(rd_data !== 16'h1234, "R9 data write ignored", rd_data, 0);
        wait_idle();
        repeat (20) @(negedge clk);
        chk(busy === 0, "R9 no second frame", busy, 0);
        chk(rd_data === phy_answer(5'h12, 5'h07), "R9 read result kept", rd_data, phy_answer(5'h12, 5'h07));

        done_flag = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule